// File: doc/BRIEF.md
# Paged NIC Control Register Bank

This block is the host-facing register file of a simple Ethernet controller. The host reaches it through an 8-bit data path and a 4-bit offset. A 2-bit page field held in the command register decides which physical register each offset reaches. At several offsets a read and a write reach two different registers. On a read, those offsets return status or tally values supplied by the neighbouring engines. On a write, they load configuration or mask registers.

The block stores the command register, the transmit page start, three configuration bytes, the six station-address bytes, the current receive page, and the interrupt status and mask registers. It exports the run/halt, transmit-request and remote-DMA command fields to the engines. One-cycle event pulses from the engines set status bits. The host clears a status bit by writing a one to it. A single level interrupt output is raised while any unmasked status bit is set. Reads have no side effects: `host_rdata` shows the register selected by the current page and offset in the same cycle. Writes take effect at the next rising clock edge.

Top module: `nic_regbank`

## Requirements
- R1: After reset the command register reads 0x01 (halt bit set, page 0, DMA command 000, start and transmit request clear). Status, mask, configuration, station address and current page are all zero, and `irq` is low.
- R2: A write at offset 0x0 stores bit0 to `ctl_stop`, bit1 to `ctl_start`, bits 5:3 to `ctl_dma_cmd` (001 read, 010 write, 011 send, 100 abort) and bits 7:6 to the page select. Reading offset 0x0 returns the whole register.
- R3: Writing a one to command bit2 sets `ctl_tx_req`. Writing a zero to bit2 leaves it unchanged. A `tx_done` pulse clears it. When a set and `tx_done` arrive in the same cycle, the set wins.
- R4: On page 1, offsets 0x1 to 0x6 hold station-address bytes 0 to 5 (byte 0 drives `station_addr[7:0]`) and offset 0x7 holds the current receive page. These offsets do not reach those registers on any other page, and a page-1 write at 0x7 leaves the interrupt status unchanged.
- R5: On page 0, offset 0x4 reads `tx_status_in` and writes the transmit page start. Offsets 0xD, 0xE and 0xF read `tally_frame_in`, `tally_crc_in` and `tally_miss_in`. Writes to 0xC, 0xD, 0xE and 0xF load the receive configuration, transmit configuration, data configuration and interrupt mask.
- R6: A pulse on `evt_in[k]` sets status bit k. The bits are: 0 frame received, 1 frame sent, 2 receive error, 3 transmit error, 4 ring overflow, 5 counter overflow, 6 remote DMA done, 7 reset state. Page 0 offset 0x7 reads the status register.
- R7: A page-0 write at offset 0x7 clears each status bit written as one and leaves bits written as zero unchanged. Writing 0xFF clears every bit.
- R8: When an event pulse and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly while the bitwise AND of status and mask is non-zero. The mask uses the same bit positions as the status register.
- R10: Offset 0x0 reaches the command register on all four pages. Every offset that no register answers on the current page reads 0x00, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Register offset |
| host_we | input | 1 | Write strobe for one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the current page and offset |
| evt_in | input | 8 | Engine event pulses, one per status bit |
| tx_done | input | 1 | Transmission finished pulse |
| tx_status_in | input | 8 | Transmit status value shown on reads |
| tally_frame_in | input | 8 | Framing error tally shown on reads |
| tally_crc_in | input | 8 | CRC error tally shown on reads |
| tally_miss_in | input | 8 | Missed frame tally shown on reads |
| ctl_stop | output | 1 | Halt command |
| ctl_start | output | 1 | Run command |
| ctl_tx_req | output | 1 | Transmit request, held until done |
| ctl_dma_cmd | output | 3 | Remote DMA command |
| tx_page_start | output | 8 | Transmit buffer page start |
| rx_config | output | 8 | Receive configuration |
| tx_config | output | 8 | Transmit configuration |
| data_config | output | 8 | Data path configuration |
| station_addr | output | 48 | Station address, byte 0 in bits 7:0 |
| cur_rx_page | output | 8 | Current receive page |
| irq | output | 1 | Level interrupt |

## Verification
The status logic is driven with single events, with events that pile up, with clears that hit only some bits, with zero writes, and with an event and a clear on the same bit in one cycle. This separates a plain register, an overwrite and a true sticky set with write-one clear. The mask is tried both covering and not covering the pending bits, so a missing AND with the mask is caught. The same offsets are written and read on pages 0, 1, 2 and 3. This exposes decoding that ignores the page or mixes up the read and write sides. The transmit request is driven by a set, by a zero write, by a done pulse, and by a set and a done pulse together.

// File: rtl/nic_regbank_pkg.sv
// Package: shared types and register offsets for the paged NIC register bank.
// Assumes a byte-wide host data path and a 4-bit offset.
package nic_regbank_pkg;

    localparam int BYTE_W = 8;
    localparam int OFF_W  = 4;

    // Command register layout, most significant field first
    typedef struct packed {
        logic [1:0] page;
        logic [2:0] dma;
        logic       tx_req;
        logic       start;
        logic       stop;
    } cmd_t;

    localparam logic [BYTE_W-1:0] CMD_RESET = 8'h01;

    localparam logic [OFF_W-1:0] OFF_CMD  = 4'h0;
    localparam logic [OFF_W-1:0] OFF_TXPG = 4'h4;
    localparam logic [OFF_W-1:0] OFF_ISR  = 4'h7;
    localparam logic [OFF_W-1:0] OFF_RCFG = 4'hC;
    localparam logic [OFF_W-1:0] OFF_TCFG = 4'hD;
    localparam logic [OFF_W-1:0] OFF_DCFG = 4'hE;
    localparam logic [OFF_W-1:0] OFF_IMR  = 4'hF;
    localparam logic [OFF_W-1:0] OFF_CUR  = 4'h7;

    // Indices into the miscellaneous byte file
    localparam int MISC_TXPG = 0;
    localparam int MISC_RCFG = 1;
    localparam int MISC_TCFG = 2;
    localparam int MISC_DCFG = 3;
    localparam int MISC_CUR  = 4;
    localparam int MISC_N    = 5;

    typedef enum logic [3:0] {
        RD_ZERO, RD_CMD, RD_TXSTAT, RD_ISR,
        RD_TALLY_F, RD_TALLY_C, RD_TALLY_M,
        RD_STATION, RD_CUR
    } rd_sel_e;

endpackage

// File: rtl/nic_page_decode.sv
// Module: turns page + offset + write strobe into register write enables
// and a read-source selection. Purely combinational. Assumes the page
// value is the registered command field, so it changes only on clock edges.
module nic_page_decode
    import nic_regbank_pkg::*;
#(
    parameter int NUM_STATION = 6
) (
    input  logic [OFF_W-1:0]       addr,
    input  logic                   we,
    input  logic [1:0]             page,
    output logic                   cmd_we,
    output logic                   isr_we,
    output logic                   imr_we,
    output logic [MISC_N-1:0]      misc_we,
    output logic [NUM_STATION-1:0] par_we,
    output rd_sel_e                rd_sel,
    output logic [$clog2(NUM_STATION)-1:0] par_idx
);
    localparam int IW = $clog2(NUM_STATION);

    // Decode of the shared offsets per page and direction
    always_comb begin
        cmd_we  = 1'b0;
        isr_we  = 1'b0;
        imr_we  = 1'b0;
        misc_we = '0;
        rd_sel  = RD_ZERO;
        if (addr == OFF_CMD) begin
            rd_sel = RD_CMD;
            cmd_we = we;
        end else begin
            case (page)
                2'd0: begin
                    case (addr)
                        OFF_TXPG: begin rd_sel = RD_TXSTAT;  misc_we[MISC_TXPG] = we; end
                        OFF_ISR:  begin rd_sel = RD_ISR;     isr_we = we; end
                        OFF_RCFG: begin misc_we[MISC_RCFG] = we; end
                        OFF_TCFG: begin rd_sel = RD_TALLY_F; misc_we[MISC_TCFG] = we; end
                        OFF_DCFG: begin rd_sel = RD_TALLY_C; misc_we[MISC_DCFG] = we; end
                        OFF_IMR:  begin rd_sel = RD_TALLY_M; imr_we = we; end
                        default:  rd_sel = RD_ZERO;
                    endcase
                end
                2'd1: begin
                    if (addr == OFF_CUR) begin
                        rd_sel = RD_CUR;
                        misc_we[MISC_CUR] = we;
                    end else if (addr >= 4'd1 && {28'd0, addr} <= NUM_STATION) begin
                        rd_sel = RD_STATION;
                    end
                end
                default: rd_sel = RD_ZERO;
            endcase
        end
    end

    // Per-byte station-address write enables on page 1
    for (genvar i = 0; i < NUM_STATION; i++) begin : g_par_we
        assign par_we[i] = we && (page == 2'd1) && (addr == OFF_W'(i + 1));
    end

    // Station byte index for the read path
    assign par_idx = IW'(addr - 4'd1);

endmodule

// File: rtl/nic_byte_file.sv
// Module: a row of byte registers, each with its own write enable and a
// shared write bus. Assumes at most one enable per cycle from the decoder.
module nic_byte_file
    import nic_regbank_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N-1:0]                we,
    input  logic [BYTE_W-1:0]           wdata,
    output logic [N-1:0][BYTE_W-1:0]    q
);
    // Load each byte whose enable is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (we[i]) q[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/nic_cmd_reg.sv
// Module: command register. Stores the page, DMA, run and halt fields on a
// host write. The transmit request is sticky: it is set by a written one and
// cleared only by the transmit engine. A set in the same cycle as done wins.
module nic_cmd_reg
    import nic_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tx_done,
    output cmd_t              cmd_q
);
    cmd_t wr;
    assign wr = cmd_t'(wdata);

    // Command fields and sticky transmit request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= cmd_t'(CMD_RESET);
        end else begin
            if (we) begin
                cmd_q.page  <= wr.page;
                cmd_q.dma   <= wr.dma;
                cmd_q.start <= wr.start;
                cmd_q.stop  <= wr.stop;
            end
            if (we && wr.tx_req) cmd_q.tx_req <= 1'b1;
            else if (tx_done)    cmd_q.tx_req <= 1'b0;
        end
    end

endmodule

// File: rtl/nic_irq_unit.sv
// Module: interrupt status and mask. Events set status bits, host writes of
// ones clear them, and an event beats a clear on the same bit. The interrupt
// is a level built from the registered status and mask.
module nic_irq_unit
    import nic_regbank_pkg::*;
#(
    parameter int NB = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          isr_we,
    input  logic          imr_we,
    input  logic [NB-1:0] wdata,
    input  logic [NB-1:0] evt,
    output logic [NB-1:0] isr_q,
    output logic [NB-1:0] imr_q,
    output logic          irq
);
    logic [NB-1:0] isr_d;

    // Per-bit next status: set by event, else write-one clear
    for (genvar i = 0; i < NB; i++) begin : g_isr_bit
        assign isr_d[i] = evt[i] | (isr_q[i] & ~(isr_we & wdata[i]));
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_d;
    end

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n)      imr_q <= '0;
        else if (imr_we) imr_q <= wdata;
    end

    // Level interrupt from unmasked pending bits
    assign irq = |(isr_q & imr_q);

endmodule

// File: rtl/nic_regbank.sv
// Module: top of the paged NIC register bank. Ties the page decoder, command
// register, interrupt unit and byte files together and builds the read path.
// Assumes a host write lasts one cycle and reads have no side effects.
module nic_regbank
    import nic_regbank_pkg::*;
#(
    parameter int NUM_STATION = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [3:0]                    host_addr,
    input  logic                          host_we,
    input  logic [7:0]                    host_wdata,
    output logic [7:0]                    host_rdata,
    input  logic [7:0]                    evt_in,
    input  logic                          tx_done,
    input  logic [7:0]                    tx_status_in,
    input  logic [7:0]                    tally_frame_in,
    input  logic [7:0]                    tally_crc_in,
    input  logic [7:0]                    tally_miss_in,
    output logic                          ctl_stop,
    output logic                          ctl_start,
    output logic                          ctl_tx_req,
    output logic [2:0]                    ctl_dma_cmd,
    output logic [7:0]                    tx_page_start,
    output logic [7:0]                    rx_config,
    output logic [7:0]                    tx_config,
    output logic [7:0]                    data_config,
    output logic [NUM_STATION*8-1:0]      station_addr,
    output logic [7:0]                    cur_rx_page,
    output logic                          irq
);
    localparam int IW = $clog2(NUM_STATION);

    logic                                 cmd_we, isr_we, imr_we;
    logic [MISC_N-1:0]                    misc_we;
    logic [NUM_STATION-1:0]               par_we;
    rd_sel_e                              rd_sel;
    logic [IW-1:0]                        par_idx;
    cmd_t                                 cmd_q;
    logic [1:0]                           page_q;
    logic [BYTE_W-1:0]                    isr_q, imr_q;
    logic [MISC_N-1:0][BYTE_W-1:0]        misc_q;
    logic [NUM_STATION-1:0][BYTE_W-1:0]   station_q;

    assign page_q = cmd_q.page;

    nic_page_decode #(.NUM_STATION(NUM_STATION)) u_decode (
        .addr    (host_addr),
        .we      (host_we),
        .page    (page_q),
        .cmd_we  (cmd_we),
        .isr_we  (isr_we),
        .imr_we  (imr_we),
        .misc_we (misc_we),
        .par_we  (par_we),
        .rd_sel  (rd_sel),
        .par_idx (par_idx)
    );

    nic_cmd_reg u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cmd_we),
        .wdata   (host_wdata),
        .tx_done (tx_done),
        .cmd_q   (cmd_q)
    );

    nic_irq_unit #(.NB(BYTE_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .isr_we (isr_we),
        .imr_we (imr_we),
        .wdata  (host_wdata),
        .evt    (evt_in),
        .isr_q  (isr_q),
        .imr_q  (imr_q),
        .irq    (irq)
    );

    nic_byte_file #(.N(MISC_N)) u_misc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (misc_we),
        .wdata (host_wdata),
        .q     (misc_q)
    );

    nic_byte_file #(.N(NUM_STATION)) u_station (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (par_we),
        .wdata (host_wdata),
        .q     (station_q)
    );

    // Exported control fields and configuration
    assign ctl_stop      = cmd_q.stop;
    assign ctl_start     = cmd_q.start;
    assign ctl_tx_req    = cmd_q.tx_req;
    assign ctl_dma_cmd   = cmd_q.dma;
    assign tx_page_start = misc_q[MISC_TXPG];
    assign rx_config     = misc_q[MISC_RCFG];
    assign tx_config     = misc_q[MISC_TCFG];
    assign data_config   = misc_q[MISC_DCFG];
    assign cur_rx_page   = misc_q[MISC_CUR];
    assign station_addr  = station_q;

    // Read multiplexer driven by the decoder's source selection
    always_comb begin
        case (rd_sel)
            RD_CMD:     host_rdata = cmd_q;
            RD_TXSTAT:  host_rdata = tx_status_in;
            RD_ISR:     host_rdata = isr_q;
            RD_TALLY_F: host_rdata = tally_frame_in;
            RD_TALLY_C: host_rdata = tally_crc_in;
            RD_TALLY_M: host_rdata = tally_miss_in;
            RD_STATION: host_rdata = station_q[par_idx];
            RD_CUR:     host_rdata = misc_q[MISC_CUR];
            default:    host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nic_regbank_chk.sv
// Module: assertion checker for nic_regbank, attached by bind below.
// Assumes the synchronous active-low reset of the top module.
module nic_regbank_chk #(
    parameter int SAW = 48
) (
    input logic           clk,
    input logic           rst_n,
    input logic [3:0]     host_addr,
    input logic           host_we,
    input logic [7:0]     host_wdata,
    input logic [7:0]     evt_in,
    input logic           tx_done,
    input logic           ctl_stop,
    input logic           ctl_tx_req,
    input logic [1:0]     page_q,
    input logic [7:0]     isr_q,
    input logic [7:0]     imr_q,
    input logic [SAW-1:0] station_addr,
    input logic           irq
);
    // R1: first cycle after reset shows the reset state
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ctl_stop && isr_q == 8'h00 && !irq));

    // R3: a written one sets the transmit request
    assert_txreq_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 4'h0 && host_wdata[2]) |=> ctl_tx_req);

    // R3: done without a new set clears the transmit request
    assert_txreq_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !(host_we && host_addr == 4'h0 && host_wdata[2])) |=> !ctl_tx_req);

    // R4: station address moves only on page-1 writes
    assert_station_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && page_q == 2'd1) |=> $stable(station_addr));

    // R6 and R8: every pulsed event bit is set on the next cycle
    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != 8'h00) |=> ((isr_q & $past(evt_in)) == $past(evt_in)));

    // R7: ones written to status without a matching event are cleared
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && page_q == 2'd0 && host_addr == 4'h7)
        |=> ((isr_q & $past(host_wdata) & ~$past(evt_in)) == 8'h00));

    // R9: the interrupt changes only when status or mask changes
    assert_irq_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(isr_q) && $stable(imr_q)) |-> $stable(irq));

endmodule

bind nic_regbank nic_regbank_chk #(.SAW(NUM_STATION*8)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr    (host_addr),
    .host_we      (host_we),
    .host_wdata   (host_wdata),
    .evt_in       (evt_in),
    .tx_done      (tx_done),
    .ctl_stop     (ctl_stop),
    .ctl_tx_req   (ctl_tx_req),
    .page_q       (page_q),
    .isr_q        (isr_q),
    .imr_q        (imr_q),
    .station_addr (station_addr),
    .irq          (irq)
);

// File: tb/nic_regbank_tb.sv
// Bench: drives host writes, events and done pulses, keeps a behavioural
// reference model in plain variables and compares every output each clock.
module nic_regbank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  d_addr = '0;
    logic        d_we = 1'b0;
    logic [7:0]  d_wd = '0;
    logic [7:0]  d_ev = '0;
    logic        d_td = 1'b0;
    logic [7:0]  txs = 8'hA5, tf = 8'h11, tc = 8'h22, tm = 8'h33;

    logic [7:0]  host_rdata, tx_page_start, rx_config, tx_config, data_config, cur_rx_page;
    logic        ctl_stop, ctl_start, ctl_tx_req, irq;
    logic [2:0]  ctl_dma_cmd;
    logic [47:0] station_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [1:0] m_page = 0;
    logic [2:0] m_dma = 0;
    logic       m_tx = 0, m_start = 0, m_stop = 1;
    logic [7:0] m_isr = 0, m_imr = 0, m_txpg = 0, m_rcfg = 0, m_tcfg = 0, m_dcfg = 0, m_cur = 0;
    logic [7:0] m_par [6] = '{default: 8'h00};

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(d_addr), .host_we(d_we),
        .host_wdata(d_wd), .host_rdata(host_rdata), .evt_in(d_ev), .tx_done(d_td),
        .tx_status_in(txs), .tally_frame_in(tf), .tally_crc_in(tc), .tally_miss_in(tm),
        .ctl_stop(ctl_stop), .ctl_start(ctl_start), .ctl_tx_req(ctl_tx_req),
        .ctl_dma_cmd(ctl_dma_cmd), .tx_page_start(tx_page_start), .rx_config(rx_config),
        .tx_config(tx_config), .data_config(data_config), .station_addr(station_addr),
        .cur_rx_page(cur_rx_page), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [47:0] m_station();
        logic [47:0] v;
        for (int i = 0; i < 6; i++) v[i*8 +: 8] = m_par[i];
        return v;
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        if (a == 4'h0) return {m_page, m_dma, m_tx, m_start, m_stop};
        if (m_page == 2'd0) begin
            case (a)
                4'h4: return txs;
                4'h7: return m_isr;
                4'hD: return tf;
                4'hE: return tc;
                4'hF: return tm;
                default: return 8'h00;
            endcase
        end
        if (m_page == 2'd1) begin
            if (a == 4'h7) return m_cur;
            if (a >= 4'h1 && a <= 4'h6) return m_par[a - 4'h1];
        end
        return 8'h00;
    endfunction

    task automatic model_step();
        logic [1:0] pg = m_page;
        if (d_we && d_addr == 4'h0) begin
            m_page = d_wd[7:6]; m_dma = d_wd[5:3]; m_start = d_wd[1]; m_stop = d_wd[0];
        end
        if (d_we && d_addr == 4'h0 && d_wd[2]) m_tx = 1'b1;
        else if (d_td) m_tx = 1'b0;
        if (d_we && d_addr != 4'h0 && pg == 2'd0) begin
            case (d_addr)
                4'h4: m_txpg = d_wd;
                4'h7: m_isr = m_isr & ~d_wd;
                4'hC: m_rcfg = d_wd;
                4'hD: m_tcfg = d_wd;
                4'hE: m_dcfg = d_wd;
                4'hF: m_imr = d_wd;
                default: ;
            endcase
        end
        if (d_we && pg == 2'd1) begin
            if (d_addr == 4'h7) m_cur = d_wd;
            else if (d_addr >= 4'h1 && d_addr <= 4'h6) m_par[d_addr - 4'h1] = d_wd;
        end
        m_isr = m_isr | d_ev;
    endtask

    task automatic compare_all();
        chk("R2 stop", ctl_stop, m_stop);
        chk("R2 start", ctl_start, m_start);
        chk("R2 dma", ctl_dma_cmd, m_dma);
        chk("R3 txreq", ctl_tx_req, m_tx);
        chk("R5 txpage", tx_page_start, m_txpg);
        chk("R5 rcfg", rx_config, m_rcfg);
        chk("R5 tcfg", tx_config, m_tcfg);
        chk("R5 dcfg", data_config, m_dcfg);
        chk("R4 station", station_addr, m_station());
        chk("R4 cur", cur_rx_page, m_cur);
        chk("R9 irq", irq, |(m_isr & m_imr));
        chk("R10 rdata", host_rdata, m_read(d_addr));
    endtask

    // one clock: apply inputs, update model at the edge, compare after it
    task automatic cyc(input logic [3:0] a, input logic we, input logic [7:0] wd,
                       input logic [7:0] ev, input logic td);
        d_addr = a; d_we = we; d_wd = wd; d_ev = ev; d_td = td;
        @(posedge clk);
        model_step();
        #1;
        d_we = 1'b0; d_ev = '0; d_td = 1'b0;
        #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] wd);
        cyc(a, 1'b1, wd, 8'h00, 1'b0);
    endtask

    task automatic rd(input logic [3:0] a, input string tag, input logic [7:0] exp);
        cyc(a, 1'b0, 8'h00, 8'h00, 1'b0);
        d_addr = a;
        #1;
        chk(tag, host_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'h0, "R1 cmd after reset", 8'h01);
        chk("R1 irq after reset", irq, 1'b0);
        chk("R1 station after reset", station_addr, 48'h0);
        rd(4'h7, "R1 status after reset", 8'h00);
        // R2 command fields
        wr(4'h0, 8'h22);
        chk("R2 start", ctl_start, 1'b1);
        chk("R2 dma abort", ctl_dma_cmd, 3'b100);
        rd(4'h0, "R2 cmd readback", 8'h22);
        // R5 mask write vs tally read at 0xF
        wr(4'hF, 8'h05);
        rd(4'hF, "R5 read 0xF tally", 8'h33);
        chk("R9 no irq with empty status", irq, 1'b0);
        // R6 events and R9 irq
        cyc(4'h7, 1'b0, 8'h00, 8'h01, 1'b0);
        chk("R9 irq on masked bit", irq, 1'b1);
        rd(4'h7, "R6 status bit0", 8'h01);
        cyc(4'h7, 1'b0, 8'h00, 8'h02, 1'b0);
        cyc(4'h7, 1'b0, 8'h00, 8'h40, 1'b0);
        rd(4'h7, "R6 accumulated", 8'h43);
        // R7 clears
        wr(4'h7, 8'h02);
        rd(4'h7, "R7 partial clear", 8'h41);
        wr(4'h7, 8'h00);
        rd(4'h7, "R7 zero write", 8'h41);
        // R8 event beats clear
        cyc(4'h7, 1'b1, 8'h01, 8'h01, 1'b0);
        rd(4'h7, "R8 event wins", 8'h41);
        wr(4'h7, 8'hFF);
        rd(4'h7, "R7 clear all", 8'h00);
        chk("R9 irq low after clear", irq, 1'b0);
        // R9 mask blocks
        cyc(4'h7, 1'b0, 8'h00, 8'h08, 1'b0);
        chk("R9 unmasked bit", irq, 1'b0);
        wr(4'hF, 8'h08);
        chk("R9 mask opens", irq, 1'b1);
        wr(4'h7, 8'hFF);
        // R3 transmit request
        wr(4'h0, 8'h26);
        chk("R3 set", ctl_tx_req, 1'b1);
        wr(4'h0, 8'h22);
        chk("R3 zero write holds", ctl_tx_req, 1'b1);
        cyc(4'h0, 1'b0, 8'h00, 8'h00, 1'b1);
        chk("R3 done clears", ctl_tx_req, 1'b0);
        cyc(4'h0, 1'b1, 8'h26, 8'h00, 1'b1);
        chk("R3 set beats done", ctl_tx_req, 1'b1);
        cyc(4'h0, 1'b0, 8'h00, 8'h00, 1'b1);
        // R5 split offsets
        wr(4'h4, 8'h40);
        chk("R5 tx page write", tx_page_start, 8'h40);
        rd(4'h4, "R5 read 0x4 tx status", 8'hA5);
        wr(4'hC, 8'h0C); wr(4'hD, 8'hE0); wr(4'hE, 8'h48);
        rd(4'hD, "R5 read 0xD tally", 8'h11);
        rd(4'hE, "R5 read 0xE tally", 8'h22);
        chk("R5 tcfg", tx_config, 8'hE0);
        // R4 page 0 offset 1 does not reach station
        wr(4'h1, 8'h99);
        chk("R4 page0 no station", station_addr, 48'h0);
        rd(4'h1, "R10 page0 unmapped", 8'h00);
        // R4 page 1
        wr(4'h0, 8'h62);
        for (int i = 0; i < 6; i++) wr(4'(i + 1), 8'(8'h10 + i));
        chk("R4 station bytes", station_addr, 48'h151413121110);
        cyc(4'h7, 1'b0, 8'h00, 8'h20, 1'b0);
        wr(4'h7, 8'hFF);
        chk("R4 cur page", cur_rx_page, 8'hFF);
        rd(4'h3, "R4 read station byte2", 8'h12);
        rd(4'h7, "R4 read cur not status", 8'hFF);
        // R10 pages 2 and 3
        wr(4'h0, 8'hA2);
        rd(4'h0, "R10 cmd on page2", 8'hA2);
        rd(4'h7, "R10 page2 unmapped", 8'h00);
        wr(4'h2, 8'h77);
        chk("R10 page2 write ignored", station_addr, 48'h151413121110);
        wr(4'h0, 8'hE2);
        rd(4'h0, "R10 cmd on page3", 8'hE2);
        wr(4'h0, 8'h22);
        rd(4'h7, "R4 status kept", 8'h20);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule